// File: doc/BRIEF.md
# Serial ADC Result Readout Port

This block is the digital serial output stage of a 12-bit converter, usable as a simulation model or on an FPGA. A host opens a frame by pulling an active-low frame select low. It then supplies a serial clock and receives a 16-bit word on one data line: four zero bits followed by the 12-bit result, MSB first. The data line has a separate drive enable, so the pad can float it when the port is not talking.

The frame select and serial clock come from the host and are asynchronous. They are synchronized into the block's system clock and edge-detected there. The conversion-busy flag and the result register are synchronous to the system clock. The result is copied into a shadow shift register when a frame is accepted. The host clock may pause and resume at any point inside a frame, so a word can be read as several byte bursts. No data is driven while a conversion is running. An access that starts during a conversion is refused for the whole frame and flagged.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `sdo_oe`, `sdo` and `rejected` are all 0.
- R2: When frame select falls while `conv_busy` is 0, the line is driven (`sdo_oe`=1) and the first bit shown is a zero pad bit. Each frame carries frame bit k = F[15-k] for k = 0..15, where F = {4'b0000, result}.
- R3: Each rising edge of the serial clock advances the line by exactly one bit, MSB first. A falling edge of the serial clock leaves the shown bit unchanged.
- R4: While the serial clock is idle inside an open frame, the current bit and the drive enable hold; the frame resumes on the next rising edge.
- R5: The result is captured at frame start. Changes on `result` during an open frame do not alter the bits shifted out.
- R6: The 16th rising edge of the serial clock in a frame floats the line. Further serial clock edges keep it floating until frame select rises.
- R7: A rising edge of frame select ends the frame at once and floats the line. The next frame starts again from the first pad bit with a freshly captured result.
- R8: If frame select falls while `conv_busy` is 1, the line stays floating for that whole frame, even after busy clears. `rejected` goes to 1 and stays 1 until the next frame start, which sets it anew from `conv_busy`.
- R9: If `conv_busy` is 1 while a frame is shifting, the line floats on the next system clock edge and stays floating for the rest of that frame, even after busy clears.
- R10: `sdo` reads 0 whenever `sdo_oe` is 0.
- R11: Serial clock edges while frame select is high have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fs_n | input | 1 | Active-low frame select from the host (asynchronous) |
| sck | input | 1 | Host serial clock (asynchronous, may pause) |
| conv_busy | input | 1 | Conversion in progress, synchronous to clk |
| result | input | RES_W (12) | Latest conversion result |
| sdo | output | 1 | Serial data, 0 when not driven |
| sdo_oe | output | 1 | Drive enable for the serial data pad |
| rejected | output | 1 | Last frame start was refused because of busy |

## Verification
Two functions can act in the same system clock cycle: a detected rising edge of the serial clock and a busy flag that aborts the frame. The bench raises `sck` and then asserts `conv_busy` exactly when the synchronized edge pulse is present, two clock edges after the `sck` change. It then expects the line to float rather than advance a bit. It also expects the line to stay floating after busy clears and more serial clock edges arrive. A frame start coinciding with busy is provoked the same way, and the bench checks that the whole frame stays floating with `rejected` held.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  // Frame controller states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // no frame open
    ST_SHIFT = 2'd1,  // frame open, line driven
    ST_HOLD  = 2'd2   // frame open, line floated until frame select rises
  } fr_state_e;

endpackage

// File: rtl/adc_sp_rstsync.sv
module adc_sp_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int             WIDTH   = 2,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= RST_VAL;
      end
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/adc_sp_shadow.sv
module adc_sp_shadow #(
  parameter int RES_W = 12,
  parameter int PAD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [RES_W-1:0] din,
  output logic             msb
);

  localparam int FRAME_W = RES_W + PAD_W;

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               sh_en;

  // next-state
  always_comb begin
    sh_d  = sh_q;
    sh_en = load | shift;
    if (load) begin
      sh_d = {{PAD_W{1'b0}}, din};
    end else if (shift) begin
      sh_d = {sh_q[FRAME_W-2:0], 1'b0};
    end
  end

  // register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign msb = sh_q[FRAME_W-1];

endmodule

// File: rtl/adc_sp_ctrl.sv
module adc_sp_ctrl
  import adc_sp_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_s,      // synchronized frame select (active low)
  input  logic sck_s,     // synchronized serial clock
  input  logic busy,
  output logic load,
  output logic shift,
  output logic drive,
  output logic rej
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam int LAST  = FRAME_W - 1;

  fr_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rej_q, rej_d;
  logic             fs_p_q, sck_p_q;
  logic             fs_fall, fs_rise, sck_rise;

  assign fs_fall  =  fs_p_q & ~fs_s;
  assign fs_rise  = ~fs_p_q &  fs_s;
  assign sck_rise = ~sck_p_q &  sck_s;

  // next-state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    rej_d = rej_q;
    load  = 1'b0;
    shift = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fs_fall) begin
          if (busy) begin
            st_d  = ST_HOLD;
            rej_d = 1'b1;
          end else begin
            st_d  = ST_SHIFT;
            rej_d = 1'b0;
            load  = 1'b1;
            cnt_d = '0;
          end
        end
      end
      ST_SHIFT: begin
        if (fs_rise) begin
          st_d = ST_IDLE;
        end else if (busy) begin
          st_d = ST_HOLD;
        end else if (sck_rise) begin
          if (cnt_q == CNT_W'(LAST)) begin
            st_d = ST_HOLD;
          end else begin
            shift = 1'b1;
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_HOLD: begin
        if (fs_rise) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rej_q   <= 1'b0;
      fs_p_q  <= 1'b1;
      sck_p_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      rej_q   <= rej_d;
      fs_p_q  <= fs_s;
      sck_p_q <= sck_s;
    end
  end

  assign drive = (st_q == ST_SHIFT);
  assign rej   = rej_q;

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W       = 12,
  parameter int PAD_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_n,
  input  logic             sck,
  input  logic             conv_busy,
  input  logic [RES_W-1:0] result,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             rejected
);

  localparam int FRAME_W = RES_W + PAD_W;

  logic       rst_i;
  logic [1:0] async_in, async_s;
  logic       load, shift, drive, sh_msb;

  adc_sp_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_no (rst_i)
  );

  // bit 1: frame select (idle high), bit 0: serial clock (idle low)
  assign async_in = {fs_n, sck};

  adc_sp_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b10)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     (async_in),
    .q     (async_s)
  );

  adc_sp_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_i),
    .fs_s  (async_s[1]),
    .sck_s (async_s[0]),
    .busy  (conv_busy),
    .load  (load),
    .shift (shift),
    .drive (drive),
    .rej   (rejected)
  );

  adc_sp_shadow #(.RES_W(RES_W), .PAD_W(PAD_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_i),
    .load  (load),
    .shift (shift),
    .din   (result),
    .msb   (sh_msb)
  );

  assign sdo_oe = drive;
  assign sdo    = sh_msb & drive;

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_busy,
  input logic sdo,
  input logic sdo_oe,
  input logic rejected
);

  // R9: busy in a cycle means the line floats on the next edge
  assert_float_on_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |=> !sdo_oe);

  // R8: a frame is only ever opened when busy was low
  assert_open_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(!conv_busy));

  // R2: the first bit of every frame is a pad zero
  assert_first_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  // R8: a refused access never drives the line
  assert_rejected_floats_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> !sdo_oe);

endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_busy (conv_busy),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe),
  .rejected  (rejected)
);

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fs_n;
  logic        sck;
  logic        conv_busy;
  logic [11:0] result;
  logic        sdo, sdo_oe, rejected;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  oe;
    logic  d;
    logic  rej;
    string tag;
  } exp_t;

  exp_t sb_q [$];

  always #2.5 clk = ~clk;

  adc_serial_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_n      (fs_n),
    .sck       (sck),
    .conv_busy (conv_busy),
    .result    (result),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .rejected  (rejected)
  );

  function automatic logic fbit(input logic [11:0] r, input int k);
    logic [15:0] f;
    f = {4'b0000, r};
    return f[15-k];
  endfunction

  // driver side: let outputs settle, then queue the expected values
  task automatic expect_out(input logic oe, input logic d, input logic rej, input string tag);
    exp_t e;
    repeat (6) @(posedge clk);
    e.oe = oe; e.d = d; e.rej = rej; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic set_sck(input logic v);
    @(posedge clk); #1 sck = v;
  endtask

  task automatic set_fs(input logic v);
    @(posedge clk); #1 fs_n = v;
  endtask

  task automatic set_busy(input logic v);
    @(posedge clk); #1 conv_busy = v;
  endtask

  // monitor: pop and compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (sdo_oe !== e.oe || sdo !== e.d || rejected !== e.rej) begin
          errors++;
          $display("FAIL %s: got oe=%b sdo=%b rej=%b, expected oe=%b sdo=%b rej=%b",
                   e.tag, sdo_oe, sdo, rejected, e.oe, e.d, e.rej);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] r;
    rst_n = 1'b0; fs_n = 1'b1; sck = 1'b0; conv_busy = 1'b0; result = 12'h000;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_out(1'b0, 1'b0, 1'b0, "R1");
    repeat (4) @(posedge clk);

    // Frame A: full frame, result change mid-frame, pause, falling edges
    r = 12'hA5C; result = r;
    set_fs(1'b0);
    expect_out(1'b1, fbit(r, 0), 1'b0, "R2");
    for (int k = 1; k < 16; k++) begin
      set_sck(1'b1);
      if (k == 5) result = 12'h3A7;
      expect_out(1'b1, fbit(r, k), 1'b0, (k >= 5) ? "R5" : "R3");
      set_sck(1'b0);
      if (k == 8) begin
        repeat (30) @(posedge clk);
        expect_out(1'b1, fbit(r, k), 1'b0, "R4");
      end else if (k == 10) begin
        expect_out(1'b1, fbit(r, k), 1'b0, "R3");
      end
    end
    set_sck(1'b1);
    expect_out(1'b0, 1'b0, 1'b0, "R6");
    set_sck(1'b0);
    set_sck(1'b1);
    expect_out(1'b0, 1'b0, 1'b0, "R6");
    set_sck(1'b0);
    set_fs(1'b1);
    expect_out(1'b0, 1'b0, 1'b0, "R7");

    // serial clock with frame select high
    for (int i = 0; i < 3; i++) begin
      set_sck(1'b1);
      set_sck(1'b0);
    end
    expect_out(1'b0, 1'b0, 1'b0, "R11");

    // Frame B: early end, then restart with fresh result
    r = 12'hFFF; result = r;
    set_fs(1'b0);
    expect_out(1'b1, fbit(r, 0), 1'b0, "R2");
    for (int k = 1; k <= 6; k++) begin
      set_sck(1'b1);
      expect_out(1'b1, fbit(r, k), 1'b0, "R3");
      set_sck(1'b0);
    end
    set_fs(1'b1);
    expect_out(1'b0, 1'b0, 1'b0, "R7");
    r = 12'h0F0; result = r;
    set_fs(1'b0);
    expect_out(1'b1, fbit(r, 0), 1'b0, "R7");
    for (int k = 1; k <= 8; k++) begin
      set_sck(1'b1);
      set_sck(1'b0);
    end
    expect_out(1'b1, fbit(r, 8), 1'b0, "R7");
    set_fs(1'b1);
    expect_out(1'b0, 1'b0, 1'b0, "R7");

    // Frame C: start while busy -> refused for the whole frame
    set_busy(1'b1);
    set_fs(1'b0);
    expect_out(1'b0, 1'b0, 1'b1, "R8");
    set_busy(1'b0);
    for (int i = 0; i < 4; i++) begin
      set_sck(1'b1);
      set_sck(1'b0);
    end
    expect_out(1'b0, 1'b0, 1'b1, "R10");
    set_fs(1'b1);
    expect_out(1'b0, 1'b0, 1'b1, "R8");

    // Frame D: clean start clears the flag; busy collides with an sck edge
    r = 12'h801; result = r;
    set_fs(1'b0);
    expect_out(1'b1, fbit(r, 0), 1'b0, "R8");
    for (int k = 1; k <= 4; k++) begin
      set_sck(1'b1);
      set_sck(1'b0);
    end
    expect_out(1'b1, fbit(r, 4), 1'b0, "R2");
    // sck rise, then busy sampled with the synchronized edge pulse
    @(posedge clk); #1 sck = 1'b1;
    @(posedge clk);
    @(posedge clk); #1 conv_busy = 1'b1;
    expect_out(1'b0, 1'b0, 1'b0, "R9");
    set_busy(1'b0);
    set_sck(1'b0);
    set_sck(1'b1);
    expect_out(1'b0, 1'b0, 1'b0, "R9");
    set_sck(1'b0);
    set_fs(1'b1);
    r = 12'hC33; result = r;
    set_fs(1'b0);
    expect_out(1'b1, fbit(r, 0), 1'b0, "R9");
    for (int k = 1; k <= 5; k++) begin
      set_sck(1'b1);
      set_sck(1'b0);
    end
    expect_out(1'b1, fbit(r, 5), 1'b0, "R3");
    set_fs(1'b1);
    expect_out(1'b0, 1'b0, 1'b0, "R7");

    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule